// File: doc/BRIEF.md
# Slave Request Decoder

This block sits beside the receive path of a serial multi-master bus node. When the strobe marking the start of the acknowledge bit of the slave address field arrives, it decides whether the local node is being addressed as a slave. It then updates a status flag that tells the rest of the node that a slave transfer is pending. In the same cycle it asks the bit-level transmitter to drive the acknowledge bit.

The decision uses four things: the received slave address, the addressing mode (individual or broadcast), the node's own 12-bit address, and whether the node is locked to one master. While locked, a frame from any other master is still acknowledged, because the transfer has to continue. Such a frame does not raise the flag. A parity error in the slave address field cannot pull down a flag that is already set. Frame reception, bit timing, parity computation and the later fields of the frame are handled elsewhere.

Top module: `sreq_decoder`

## Requirements
- R1: While `rst` (synchronous, active high) is sampled high, `slave_req` becomes 0 at that clock edge and `ack_req` is 0.
- R2: `slave_req` changes only at a clock edge where `ack_strobe` is 1. At every other edge it keeps its value.
- R3: When unlocked and in individual mode (`bcast`=0), a slave address equal to `unit_addr` sets `slave_req`, whatever `master_addr` holds.
- R4: A group address sets `slave_req` in both modes. A group address has bits [11:8] equal to `unit_addr[11:8]` and bits [7:0] equal to 8'hFF.
- R5: When unlocked and in broadcast mode (`bcast`=1), a slave address of 12'hFFF sets `slave_req`. A plain match to `unit_addr` that is neither a group address nor 12'hFFF does not set it.
- R6: When `locked`=1, a strobe sets `slave_req` only if `master_addr` equals `lock_master` and the address condition of R3 to R5 holds.
- R7: When `locked`=1 and the address condition holds but `master_addr` differs from `lock_master`, `ack_req` is 1 in the strobe cycle and `slave_req` is cleared, not set.
- R8: When the strobe arrives, the request condition fails and `sa_parity_err`=0, `slave_req` is cleared at that edge.
- R9: When the strobe arrives with `sa_parity_err`=1, `slave_req`=1 and the request condition failing, `slave_req` stays 1.
- R10: `ack_req` is combinational and is 1 exactly in a cycle where `ack_strobe`=1 and the address condition holds, regardless of lock state or parity error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ack_strobe | input | 1 | One-cycle strobe at the start of the slave-address acknowledge bit |
| bcast | input | 1 | Addressing mode: 0 individual, 1 broadcast |
| master_addr | input | 12 | Received master address |
| slave_addr | input | 12 | Received slave address |
| unit_addr | input | 12 | Local node address |
| locked | input | 1 | Node is locked to one master |
| lock_master | input | 12 | Address of the locking master |
| sa_parity_err | input | 1 | Parity error seen in the slave address field |
| slave_req | output | 1 | Slave request status flag |
| ack_req | output | 1 | Request to drive the acknowledge bit, same cycle as the strobe |

## Verification
The acknowledge request and the flag update both happen in the strobe cycle, and they can disagree. A locked node addressed by a foreign master acknowledges while its flag falls. If the same frame also carries a parity error and the flag was already set, the node acknowledges while its flag holds. The bench drives both combinations from a set flag. It reads `ack_req` one time unit after the strobe is applied, and reads `slave_req` at the following falling edge. This confirms that each output follows its own rule.

// File: rtl/sreq_pkg.sv
package sreq_pkg;

    localparam int ADDR_W = 12;
    localparam int GRP_W  = 4;
    localparam int LOW_W  = ADDR_W - GRP_W;

    typedef logic [ADDR_W-1:0] addr_t;

    typedef enum logic {
        MODE_INDIV = 1'b0,
        MODE_BCAST = 1'b1
    } mode_e;

    typedef struct packed {
        logic own;
        logic group;
        logic all_ones;
    } match_t;

    typedef struct packed {
        logic hit;
        logic master_ok;
        logic request;
    } verdict_t;

    function automatic logic is_group(addr_t sa, addr_t ua);
        return (sa[ADDR_W-1 -: GRP_W] == ua[ADDR_W-1 -: GRP_W]) && (&sa[LOW_W-1:0]);
    endfunction

    function automatic logic mode_hit(match_t m, mode_e md);
        if (md == MODE_BCAST)
            return m.all_ones | m.group;
        else
            return m.own | m.group;
    endfunction

endpackage

// File: rtl/sreq_addr_match.sv
module sreq_addr_match
    import sreq_pkg::*;
(
    input  addr_t  slave_addr,
    input  addr_t  unit_addr,
    input  mode_e  mode,
    output match_t match,
    output logic   hit
);

    always_comb begin
        match.own      = (slave_addr == unit_addr);
        match.group    = is_group(slave_addr, unit_addr);
        match.all_ones = &slave_addr;
        hit            = mode_hit(match, mode);
    end

endmodule

// File: rtl/sreq_lock_qual.sv
module sreq_lock_qual
    import sreq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     hit,
    input  logic     locked,
    input  addr_t    master_addr,
    input  addr_t    lock_master,
    output verdict_t verdict
);

    always_comb begin
        verdict.hit       = hit;
        verdict.master_ok = !locked || (master_addr == lock_master);
        verdict.request   = verdict.hit && verdict.master_ok;
    end

    // R6
    locked_src_chk: assert property (@(posedge clk) disable iff (rst)
        (locked && (master_addr != lock_master)) |-> !verdict.request);

    // R3
    unlocked_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (!locked && hit) |-> verdict.request);

endmodule

// File: rtl/sreq_flag_reg.sv
module sreq_flag_reg (
    input  logic clk,
    input  logic rst,
    input  logic strobe,
    input  logic request,
    input  logic parity_err,
    output logic flag
);

    always_ff @(posedge clk) begin
        if (rst)
            flag <= 1'b0;
        else if (strobe) begin
            if (request)
                flag <= 1'b1;
            else if (parity_err)
                flag <= flag;
            else
                flag <= 1'b0;
        end
    end

    // R1
    flag_reset_chk: assert property (@(posedge clk) rst |=> !flag);

    // R2
    flag_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !strobe |=> $stable(flag));

    // R8
    flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (strobe && !request && !parity_err) |=> !flag);

    // R9
    flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (strobe && !request && parity_err && flag) |=> flag);

endmodule

// File: rtl/sreq_decoder.sv
module sreq_decoder
    import sreq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        ack_strobe,
    input  logic        bcast,
    input  logic [11:0] master_addr,
    input  logic [11:0] slave_addr,
    input  logic [11:0] unit_addr,
    input  logic        locked,
    input  logic [11:0] lock_master,
    input  logic        sa_parity_err,
    output logic        slave_req,
    output logic        ack_req
);

    match_t   match;
    logic     hit;
    verdict_t verdict;
    mode_e    mode;

    assign mode = mode_e'(bcast);

    sreq_addr_match u_match (
        .slave_addr (slave_addr),
        .unit_addr  (unit_addr),
        .mode       (mode),
        .match      (match),
        .hit        (hit)
    );

    sreq_lock_qual u_qual (
        .clk         (clk),
        .rst         (rst),
        .hit         (hit),
        .locked      (locked),
        .master_addr (master_addr),
        .lock_master (lock_master),
        .verdict     (verdict)
    );

    sreq_flag_reg u_flag (
        .clk        (clk),
        .rst        (rst),
        .strobe     (ack_strobe),
        .request    (verdict.request),
        .parity_err (sa_parity_err),
        .flag       (slave_req)
    );

    assign ack_req = ack_strobe && verdict.hit && !rst;

    // R10
    ack_covers_req_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_strobe && verdict.request) |-> ack_req);

    // R10
    ack_needs_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        ack_req |-> ack_strobe);

    // R5
    bcast_own_only_chk: assert property (@(posedge clk) disable iff (rst)
        (bcast && !match.group && !match.all_ones) |-> !ack_req);

    // R7
    foreign_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_strobe && verdict.hit && !verdict.master_ok) |-> ack_req);

endmodule

// File: tb/sim_sreq_decoder.sv
module sim_sreq_decoder;

    localparam time CLK_PERIOD = 10ns;
    localparam logic [11:0] UNIT  = 12'h3A5;
    localparam logic [11:0] GROUP = 12'h3FF;
    localparam logic [11:0] LOCKM = 12'h456;
    localparam logic [11:0] OTHER = 12'h120;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ack_strobe = 1'b0;
    logic        bcast = 1'b0;
    logic [11:0] master_addr = 12'h000;
    logic [11:0] slave_addr = 12'h000;
    logic [11:0] unit_addr = UNIT;
    logic        locked = 1'b0;
    logic [11:0] lock_master = LOCKM;
    logic        sa_parity_err = 1'b0;
    logic        slave_req;
    logic        ack_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sreq_decoder u0 (
        .clk(clk), .rst(rst), .ack_strobe(ack_strobe), .bcast(bcast),
        .master_addr(master_addr), .slave_addr(slave_addr), .unit_addr(unit_addr),
        .locked(locked), .lock_master(lock_master), .sa_parity_err(sa_parity_err),
        .slave_req(slave_req), .ack_req(ack_req)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    // one strobe cycle; check ack during it, flag after the edge
    task automatic frame(input logic md, input logic [11:0] ma, input logic [11:0] sa,
                         input logic lk, input logic pe, input logic exp_ack,
                         input logic exp_flag, input string tag);
        @(negedge clk);
        bcast = md; master_addr = ma; slave_addr = sa; locked = lk; sa_parity_err = pe;
        ack_strobe = 1'b1;
        #1;
        chk({tag, " ack"}, ack_req, exp_ack);
        @(negedge clk);
        ack_strobe = 1'b0; sa_parity_err = 1'b0;
        chk({tag, " flag"}, slave_req, exp_flag);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R1 reset flag", slave_req, 1'b0);
        chk("R1 reset ack", ack_req, 1'b0);
        ack_strobe = 1'b1; slave_addr = UNIT; #1;
        chk("R1 ack gated in reset", ack_req, 1'b0);
        @(negedge clk);
        ack_strobe = 1'b0;
        chk("R1 flag held low in reset", slave_req, 1'b0);
        rst = 1'b0;
    endtask

    task automatic t_individual;
        frame(1'b0, OTHER, UNIT, 1'b0, 1'b0, 1'b1, 1'b1, "R3 own addr");
        frame(1'b0, 12'h000, 12'h3A4, 1'b0, 1'b0, 1'b0, 1'b0, "R8 miss clears");
        frame(1'b0, 12'hFED, UNIT, 1'b0, 1'b0, 1'b1, 1'b1, "R3 master ignored");
    endtask

    task automatic t_quiet;
        @(negedge clk);
        slave_addr = 12'h000; bcast = 1'b0; locked = 1'b0;
        repeat (3) @(negedge clk);
        chk("R2 flag stable without strobe", slave_req, 1'b1);
        chk("R10 no ack without strobe", ack_req, 1'b0);
        slave_addr = UNIT; #1;
        chk("R10 no ack on hit without strobe", ack_req, 1'b0);
    endtask

    task automatic t_group_bcast;
        frame(1'b0, OTHER, 12'h000, 1'b0, 1'b0, 1'b0, 1'b0, "R8 clear");
        frame(1'b0, OTHER, GROUP, 1'b0, 1'b0, 1'b1, 1'b1, "R4 group indiv");
        frame(1'b1, OTHER, 12'h3FE, 1'b0, 1'b0, 1'b0, 1'b0, "R8 near group");
        frame(1'b1, OTHER, GROUP, 1'b0, 1'b0, 1'b1, 1'b1, "R4 group bcast");
        frame(1'b1, OTHER, UNIT, 1'b0, 1'b0, 1'b0, 1'b0, "R5 own addr in bcast");
        frame(1'b1, OTHER, 12'hFFF, 1'b0, 1'b0, 1'b1, 1'b1, "R5 all ones");
        frame(1'b0, OTHER, 12'hFFF, 1'b0, 1'b0, 1'b0, 1'b0, "R5 all ones indiv");
    endtask

    task automatic t_lock;
        frame(1'b0, LOCKM, UNIT, 1'b1, 1'b0, 1'b1, 1'b1, "R6 lock master");
        frame(1'b0, OTHER, UNIT, 1'b1, 1'b0, 1'b1, 1'b0, "R7 foreign master");
        frame(1'b1, LOCKM, 12'hFFF, 1'b1, 1'b0, 1'b1, 1'b1, "R6 lock bcast");
        frame(1'b0, LOCKM, 12'h777, 1'b1, 1'b0, 1'b0, 1'b0, "R6 lock master miss");
    endtask

    task automatic t_parity;
        frame(1'b0, OTHER, UNIT, 1'b0, 1'b0, 1'b1, 1'b1, "R3 prep");
        frame(1'b0, OTHER, 12'h001, 1'b0, 1'b1, 1'b0, 1'b1, "R9 perr holds");
        frame(1'b0, OTHER, UNIT, 1'b1, 1'b1, 1'b1, 1'b1, "R7 R9 foreign perr hold");
        frame(1'b0, OTHER, UNIT, 1'b1, 1'b0, 1'b1, 1'b0, "R7 foreign clears");
        frame(1'b0, OTHER, 12'h001, 1'b0, 1'b1, 1'b0, 1'b0, "R9 perr stays low");
    endtask

    task automatic finish_run;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (2) @(posedge clk);
        t_reset();
        t_individual();
        t_quiet();
        t_group_bcast();
        t_lock();
        t_parity();
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            finish_run();
        end
    end

endmodule